// File: doc/BRIEF.md
# Write-Through Data Cache with Mode-Tagged Lines

This block is a small direct-mapped data cache placed between a 32-bit CPU load/store port and a slower single-beat memory bus. It holds 256 bytes as 16 lines of four 32-bit words. Each line carries one tag, built from the upper address bits and the access mode (supervisor or user), and one valid bit per word. Reads that hit complete at once. Every other access runs one bus transaction, and every write goes to the bus.

Two sources can mark an access non-cacheable. The first is a page attribute that arrives with the request from the address-translation unit. The second is an inhibit input that the bus returns together with its acknowledge. Both sources apply to writes as well as reads. A control input decides whether a full, aligned word write that misses may create an entry. Software can also clear every line at once or invalidate a single line by index.

Top module: `wt_dcache`

## Requirements
- R1: After reset no word is valid, so the first read of any address completes only together with a bus acknowledge.
- R2: A read with the page attribute clear completes in its request cycle without a bus request when the indexed line's tag matches both the address and the mode and the word's valid bit is set. It returns the stored word.
- R3: A cacheable read miss stores the returned word and sets its valid bit. If the line's tag differed, the line is retagged and its other words become invalid.
- R4: A read with the page inhibit set always uses the bus. A read acknowledged with bus inhibit high is not stored, so a repeated read goes to the bus again and returns the device's new value.
- R5: Every write issues exactly one bus write. Byte enables are bit k for byte lane k (data bits 8k+7:8k). Size 00 (byte) enables lane addr[1:0]. Size 01 (half) enables lanes 1:0 when addr[1] is 0 and lanes 3:2 otherwise. Size 10 (word) enables all four lanes. Write data is already placed in lane position.
- R6: A write hit that is not inhibited updates only the enabled byte lanes of the cached word.
- R7: With the allocate control high, a write miss of size 10 to an address with addr[1:0]=00 creates the entry. Byte, half and unaligned writes never allocate, and no write allocates while the control is low.
- R8: A write with page inhibit set, or acknowledged with bus inhibit high, neither creates nor updates an entry, even when allocation is enabled.
- R9: With allocation off, the sequence supervisor read, supervisor write, user write, supervisor read to one address returns the supervisor write's data as a hit.
- R10: With allocation on, a supervisor write followed by a user write to one address makes a later supervisor read miss and return the user write's data.
- R11: A clear-all pulse invalidates every word in one clock. A line-invalidate pulse invalidates only the line at its index.
- R12: When a line invalidate falls in the same cycle as a fill into that line, the line ends up invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_alloc_en | input | 1 | Allow qualifying write misses to allocate |
| clear_all | input | 1 | Invalidate every line |
| inv_line | input | 1 | Invalidate the line at inv_index |
| inv_index | input | 4 | Line index to invalidate |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| cpu_size | input | 2 | 00 byte, 01 half, 10 word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data in lane position |
| cpu_pg_inh | input | 1 | Page cache-inhibit attribute from translation |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Bus request, held until mem_ack |
| mem_we | output | 1 | Bus write |
| mem_addr | output | 32 | Bus address |
| mem_be | output | 4 | Bus byte enables |
| mem_wdata | output | 32 | Bus write data |
| mem_rdata | input | 32 | Bus read data, valid with mem_ack |
| mem_ack | input | 1 | Bus completes this cycle |
| mem_inh | input | 1 | Bus cache-inhibit, sampled with mem_ack |

## Verification
A line invalidate can arrive on the same clock edge at which a bus read returns data into that very line. The bench provokes this by pulsing the invalidate from its bus model in exactly the acknowledge cycle of a read. It judges the result by repeating the read, which must go to the bus again. A device register whose read value changes on every access catches any entry wrongly created on an inhibited write, because a hit would return a repeated or written value instead of the next one.

// File: rtl/wt_dcache_pkg.sv
// Shared types and lane helpers for the write-through data cache.
// Assumes a 32-bit data path with four byte lanes, lane k = bits 8k+7:8k.
package wt_dcache_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } xfer_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } ctl_state_e;

    // Byte-lane enables for a transfer of the given size at the given offset.
    function automatic logic [3:0] lane_enable(input logic [1:0] size, input logic [1:0] ofs);
        case (size)
            SZ_BYTE: return 4'b0001 << ofs;
            SZ_HALF: return ofs[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/wt_dcache_lanes.sv
// Decodes the byte-lane enables of a CPU access and whether the access is a
// full aligned word, the only shape that may allocate on a write miss.
// Assumes size and offset are held stable for the whole request.
module wt_dcache_lanes
    import wt_dcache_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] ofs,
    output logic [3:0] be,
    output logic       full_word
);
    // Lane decode and full-word qualification.
    always_comb begin
        be        = lane_enable(size, ofs);
        full_word = (size == SZ_WORD) && (ofs == 2'b00);
    end
endmodule

// File: rtl/wt_dcache_store.sv
// Tag, per-word valid and data arrays with one lookup and one write port.
// The write port targets the lookup index and word. A retag write replaces the
// tag and, when the tag changes, leaves only the written word valid.
// Invalidates are applied after the write, so they win on a collision.
module wt_dcache_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 25,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int WSL_W = $clog2(WORDS),
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_index,
    input  logic [WSL_W-1:0]  lk_word,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic              wr_retag,
    input  logic [LANES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clear_all,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_index
);
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [WORDS-1:0]  val_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES][WORDS];
    logic              tag_same;
    logic [WORDS-1:0]  word_bit;

    // Lookup of the indexed line.
    always_comb begin
        tag_same = (tag_q[lk_index] == lk_tag);
        lk_hit   = val_q[lk_index][lk_word] && tag_same;
        lk_data  = dat_q[lk_index][lk_word];
        word_bit = {{(WORDS-1){1'b0}}, 1'b1} << lk_word;
    end

    // Tag and valid state: fill/retag first, then invalidates override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                val_q[i] <= '0;
            end
        end else begin
            if (wr_en) begin
                if (wr_retag && !tag_same) begin
                    tag_q[lk_index] <= lk_tag;
                    val_q[lk_index] <= word_bit;
                end else begin
                    val_q[lk_index] <= val_q[lk_index] | word_bit;
                end
            end
            if (inv_en) begin
                val_q[inv_index] <= '0;
            end
            if (clear_all) begin
                for (int i = 0; i < LINES; i++) begin
                    val_q[i] <= '0;
                end
            end
        end
    end

    // Data lanes: each enabled byte lane of the addressed word is written.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) begin
                dat_q[lk_index][lk_word][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end
endmodule

// File: rtl/wt_dcache_ctrl.sv
// Access sequencer: completes read hits at once, otherwise runs one bus beat
// and decides at the acknowledge whether the arrays are written.
// Assumes the CPU holds its request stable until cpu_ready.
module wt_dcache_ctrl
    import wt_dcache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic cpu_pg_inh,
    input  logic wr_alloc_en,
    input  logic lk_hit,
    input  logic full_word,
    input  logic mem_ack,
    input  logic mem_inh,
    output logic cpu_ready,
    output logic bus_phase,
    output logic wr_en,
    output logic wr_retag,
    output logic wr_full
);
    ctl_state_e state_q, state_d;
    logic       rd_hit, done, cacheable;

    // Completion and array-write decisions.
    always_comb begin
        rd_hit    = (state_q == ST_IDLE) && cpu_req && !cpu_we && !cpu_pg_inh && lk_hit;
        done      = (state_q == ST_BUS) && mem_ack;
        cacheable = !cpu_pg_inh && !mem_inh;
        cpu_ready = rd_hit || done;
        bus_phase = (state_q == ST_BUS);
        wr_en     = done && cacheable && (!cpu_we || lk_hit || (wr_alloc_en && full_word));
        wr_retag  = !lk_hit;
        wr_full   = !cpu_we || !lk_hit;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (cpu_req && !rd_hit) state_d = ST_BUS;
            ST_BUS:  if (mem_ack)            state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/wt_dcache.sv
// Direct-mapped write-through data cache, tagged by address and mode.
// Assumes a single outstanding CPU access and a single-beat memory bus.
module wt_dcache #(
    parameter int ADDR_W    = 32,
    parameter int LINES     = 16,
    parameter int WORDS     = 4,
    localparam int DATA_W   = 32,
    localparam int LANES    = DATA_W / 8,
    localparam int IDX_W    = $clog2(LINES),
    localparam int WSL_W    = $clog2(WORDS),
    localparam int OFS_W    = IDX_W + WSL_W + 2,
    localparam int TAG_W    = ADDR_W - OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_alloc_en,
    input  logic              clear_all,
    input  logic              inv_line,
    input  logic [IDX_W-1:0]  inv_index,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_super,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_pg_inh,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_inh
);
    logic [LANES-1:0]  be;
    logic              full_word, lk_hit, bus_phase;
    logic              wr_en, wr_retag, wr_full;
    logic [DATA_W-1:0] lk_data, wr_data;
    logic [TAG_W-1:0]  lk_tag;

    wt_dcache_lanes u_lanes (
        .size      (cpu_size),
        .ofs       (cpu_addr[1:0]),
        .be        (be),
        .full_word (full_word)
    );

    wt_dcache_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_pg_inh  (cpu_pg_inh),
        .wr_alloc_en (wr_alloc_en),
        .lk_hit      (lk_hit),
        .full_word   (full_word),
        .mem_ack     (mem_ack),
        .mem_inh     (mem_inh),
        .cpu_ready   (cpu_ready),
        .bus_phase   (bus_phase),
        .wr_en       (wr_en),
        .wr_retag    (wr_retag),
        .wr_full     (wr_full)
    );

    // Tag formation and write-port data selection.
    always_comb begin
        lk_tag  = {cpu_super, cpu_addr[ADDR_W-1:OFS_W]};
        wr_data = cpu_we ? cpu_wdata : mem_rdata;
    end

    wt_dcache_store #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_index  (cpu_addr[OFS_W-1:WSL_W+2]),
        .lk_word   (cpu_addr[WSL_W+1:2]),
        .lk_tag    (lk_tag),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data),
        .wr_en     (wr_en),
        .wr_retag  (wr_retag),
        .wr_be     (wr_full ? {LANES{1'b1}} : be),
        .wr_data   (wr_data),
        .clear_all (clear_all),
        .inv_en    (inv_line),
        .inv_index (inv_index)
    );

    // Bus side mirrors the held CPU request; read data comes from bus or array.
    always_comb begin
        mem_req   = bus_phase;
        mem_we    = cpu_we;
        mem_addr  = cpu_addr;
        mem_be    = be;
        mem_wdata = cpu_wdata;
        cpu_rdata = bus_phase ? mem_rdata : lk_data;
    end
endmodule

// File: rtl/wt_dcache_chk.sv
// Protocol and rule checks for wt_dcache, attached by bind.
module wt_dcache_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_all,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [1:0]        cpu_size,
    input logic              cpu_pg_inh,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [3:0]        mem_be,
    input logic              mem_ack
);
    // R5: a bus request is held until acknowledged.
    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req);

    // R5: a write only completes with a bus acknowledge.
    assert_write_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && cpu_ready |-> mem_req && mem_ack);

    // R5: a byte write enables exactly one lane, a word write all four.
    assert_byte_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && cpu_size == 2'b00 |-> $countones(mem_be) == 1);
    assert_word_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && cpu_size == 2'b10 |-> mem_be == 4'hF);

    // R4: a read with page inhibit never completes from the array.
    assert_pg_inh_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_we && cpu_pg_inh && cpu_ready |-> mem_ack);

    // R11: right after a clear-all no access can hit.
    assert_clear_no_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> !(cpu_ready && !mem_ack));
endmodule

bind wt_dcache wt_dcache_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_all  (clear_all),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_size   (cpu_size),
    .cpu_pg_inh (cpu_pg_inh),
    .cpu_ready  (cpu_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .mem_ack    (mem_ack)
);

// File: tb/sim_wt_dcache.sv
module sim_wt_dcache;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        we;
        logic        sup;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  ebe;
        logic        ebus;
    } vec_t;

    // Table of accesses with allocation off; reads check data, writes check lanes.
    localparam vec_t VEC [13] = '{
        '{1'b0, 1'b1, 2'b10, 32'h040, 32'h0,        32'hC0DE0010, 4'h0,    1'b1}, // R1 R3
        '{1'b0, 1'b1, 2'b10, 32'h040, 32'h0,        32'hC0DE0010, 4'h0,    1'b0}, // R2
        '{1'b0, 1'b1, 2'b10, 32'h044, 32'h0,        32'hC0DE0011, 4'h0,    1'b1}, // R3
        '{1'b0, 1'b1, 2'b10, 32'h040, 32'h0,        32'hC0DE0010, 4'h0,    1'b0}, // R3 keep
        '{1'b1, 1'b1, 2'b00, 32'h041, 32'h0000AB00, 32'h0,        4'b0010, 1'b1}, // R5 byte
        '{1'b0, 1'b1, 2'b10, 32'h040, 32'h0,        32'hC0DEAB10, 4'h0,    1'b0}, // R6
        '{1'b0, 1'b1, 2'b10, 32'h140, 32'h0,        32'hC0DE0050, 4'h0,    1'b1}, // R3 retag
        '{1'b0, 1'b1, 2'b10, 32'h044, 32'h0,        32'hC0DE0011, 4'h0,    1'b1}, // R3 cleared
        '{1'b0, 1'b1, 2'b10, 32'h040, 32'h0,        32'hC0DEAB10, 4'h0,    1'b1}, // R3 cleared
        '{1'b1, 1'b1, 2'b01, 32'h042, 32'h12340000, 32'h0,        4'b1100, 1'b1}, // R5 half
        '{1'b0, 1'b1, 2'b10, 32'h040, 32'h0,        32'h1234AB10, 4'h0,    1'b0}, // R6
        '{1'b0, 1'b0, 2'b10, 32'h040, 32'h0,        32'h1234AB10, 4'h0,    1'b1}, // R2 mode
        '{1'b0, 1'b1, 2'b10, 32'h044, 32'h0,        32'hC0DE0011, 4'h0,    1'b1}  // R3 mode
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_alloc_en = 1'b0, clear_all = 1'b0, tb_inv = 1'b0, mem_inv = 1'b0;
    logic        inv_line;
    logic [3:0]  inv_index = '0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_super = 1'b1, cpu_pg_inh = 1'b0;
    logic [1:0]  cpu_size = 2'b10;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, mem_req, mem_we;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0, mem_inh = 1'b0;

    logic [31:0] mem [256];
    logic [31:0] dev_base = '0, dev_cnt = '0;
    logic [3:0]  last_be = '0;
    logic        arm_inv = 1'b0;
    int          bus_cnt = 0, tests = 0, fails = 0;
    logic [31:0] rd;
    int          nb;

    assign inv_line = tb_inv | mem_inv;

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_dcache u0 (.*);

    // Bus model: one-cycle acknowledge; addr[31] selects an inhibited device
    // whose read value advances on every read.
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 | i;
        forever begin
            @(negedge clk);
            mem_inv = 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack = 1'b1;
                bus_cnt++;
                last_be = mem_be;
                if (mem_addr[31]) begin
                    mem_inh = 1'b1;
                    if (mem_we) begin dev_base = mem_wdata; dev_cnt = '0; end
                    else begin dev_cnt++; mem_rdata = dev_base + dev_cnt; end
                end else begin
                    mem_inh = 1'b0;
                    if (mem_we) begin
                        for (int b = 0; b < 4; b++)
                            if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                    end else mem_rdata = mem[mem_addr[9:2]];
                end
                if (arm_inv) begin mem_inv = 1'b1; arm_inv = 1'b0; end
            end else begin
                mem_ack = 1'b0;
                mem_inh = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One CPU access; returns read data and the number of bus beats it used.
    task automatic access(input logic we, input logic sup, input logic [1:0] sz,
                          input logic [31:0] addr, input logic [31:0] wd, input logic pinh,
                          output logic [31:0] data, output int beats);
        int start;
        @(negedge clk);
        start = bus_cnt;
        cpu_req = 1'b1; cpu_we = we; cpu_super = sup; cpu_size = sz;
        cpu_addr = addr; cpu_wdata = wd; cpu_pg_inh = pinh;
        forever begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
        end
        data  = cpu_rdata;
        beats = bus_cnt - start;
        @(posedge clk);
        #1 cpu_req = 1'b0;
    endtask

    task automatic pulse_inv(input logic [3:0] idx);
        @(negedge clk); inv_index = idx; tb_inv = 1'b1;
        @(negedge clk); tb_inv = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(cpu_ready == 1'b0 && mem_req == 1'b0, "R1 idle", {cpu_ready, mem_req}, 0);
        @(negedge clk) rst_n = 1'b1;

        // Table walk: R1 R2 R3 R5 R6.
        for (int v = 0; v < 13; v++) begin
            access(VEC[v].we, VEC[v].sup, VEC[v].sz, VEC[v].addr, VEC[v].wd, 1'b0, rd, nb);
            check(nb == int'(VEC[v].ebus), $sformatf("R2/R3 bus use vec %0d", v), nb, VEC[v].ebus);
            if (VEC[v].we) check(last_be == VEC[v].ebe, $sformatf("R5 lanes vec %0d", v), last_be, VEC[v].ebe);
            else           check(rd == VEC[v].exp, $sformatf("R6 data vec %0d", v), rd, VEC[v].exp);
        end

        // R7: only full aligned words allocate, and only with the control high.
        wr_alloc_en = 1'b1;
        access(1, 1, 2'b10, 32'h080, 32'hAAAA0001, 0, rd, nb);
        access(0, 1, 2'b10, 32'h080, 0, 0, rd, nb);
        check(nb == 0 && rd == 32'hAAAA0001, "R7 word allocates", rd, 32'hAAAA0001);
        access(1, 1, 2'b00, 32'h0C1, 32'h00007700, 0, rd, nb);
        access(0, 1, 2'b10, 32'h0C0, 0, 0, rd, nb);
        check(nb == 1, "R7 byte no allocate", nb, 1);
        access(1, 1, 2'b10, 32'h0D2, 32'h99990000, 0, rd, nb);
        access(0, 1, 2'b10, 32'h0D0, 0, 0, rd, nb);
        check(nb == 1, "R7 unaligned no allocate", nb, 1);
        wr_alloc_en = 1'b0;
        access(1, 1, 2'b10, 32'h0E0, 32'h5A5A5A5A, 0, rd, nb);
        access(0, 1, 2'b10, 32'h0E0, 0, 0, rd, nb);
        check(nb == 1 && rd == 32'h5A5A5A5A, "R7 control low", nb, 1);

        // R8: page-inhibited writes neither allocate nor update.
        wr_alloc_en = 1'b1;
        access(1, 1, 2'b10, 32'h100, 32'h01010101, 1, rd, nb);
        access(0, 1, 2'b10, 32'h100, 0, 0, rd, nb);
        check(nb == 1, "R8 page inhibit no allocate", nb, 1);
        access(1, 1, 2'b10, 32'h080, 32'hBBBB0002, 1, rd, nb);
        access(0, 1, 2'b10, 32'h080, 0, 0, rd, nb);
        check(nb == 0 && rd == 32'hAAAA0001, "R8 page inhibit no update", rd, 32'hAAAA0001);

        // R4: page-inhibited read goes to the bus.
        access(0, 1, 2'b10, 32'h080, 0, 1, rd, nb);
        check(nb == 1 && rd == 32'hBBBB0002, "R4 page inhibit read", rd, 32'hBBBB0002);

        // R4 R8: device behind bus inhibit, written with allocation on.
        access(1, 1, 2'b10, 32'h80000010, 32'h00000055, 0, rd, nb);
        access(0, 1, 2'b10, 32'h80000010, 0, 0, rd, nb);
        check(nb == 1 && rd == 32'h56, "R8 bus inhibit write not cached", rd, 32'h56);
        access(0, 1, 2'b10, 32'h80000010, 0, 0, rd, nb);
        check(nb == 1 && rd == 32'h57, "R4 bus inhibit read not cached", rd, 32'h57);

        // R9: mode separation without allocation returns stale supervisor data.
        wr_alloc_en = 1'b0;
        access(0, 1, 2'b10, 32'h200, 0, 0, rd, nb);
        access(1, 1, 2'b10, 32'h200, 32'h11111111, 0, rd, nb);
        access(1, 0, 2'b10, 32'h200, 32'h22222222, 0, rd, nb);
        access(0, 1, 2'b10, 32'h200, 0, 0, rd, nb);
        check(nb == 0 && rd == 32'h11111111, "R9 stale supervisor hit", rd, 32'h11111111);

        // R10: with allocation, the user write retags and the read sees it.
        wr_alloc_en = 1'b1;
        access(1, 1, 2'b10, 32'h300, 32'h33333333, 0, rd, nb);
        access(1, 0, 2'b10, 32'h300, 32'h44444444, 0, rd, nb);
        access(0, 1, 2'b10, 32'h300, 0, 0, rd, nb);
        check(nb == 1 && rd == 32'h44444444, "R10 latest data", rd, 32'h44444444);
        wr_alloc_en = 1'b0;

        // R11: line invalidate is selective, clear-all is global.
        access(0, 1, 2'b10, 32'h400, 0, 0, rd, nb);
        access(0, 1, 2'b10, 32'h410, 0, 0, rd, nb);
        pulse_inv(4'd1);
        access(0, 1, 2'b10, 32'h400, 0, 0, rd, nb);
        check(nb == 0, "R11 other line kept", nb, 0);
        access(0, 1, 2'b10, 32'h410, 0, 0, rd, nb);
        check(nb == 1, "R11 line invalidated", nb, 1);
        @(negedge clk) clear_all = 1'b1;
        @(negedge clk) clear_all = 1'b0;
        access(0, 1, 2'b10, 32'h400, 0, 0, rd, nb);
        check(nb == 1, "R11 clear all", nb, 1);

        // R12: invalidate in the same cycle as a fill into that line.
        inv_index = 4'd2;
        arm_inv   = 1'b1;
        access(0, 1, 2'b10, 32'h420, 0, 0, rd, nb);
        access(0, 1, 2'b10, 32'h420, 0, 0, rd, nb);
        check(nb == 1, "R12 invalidate wins over fill", nb, 1);

        finish_run();
    end
endmodule